// File: doc/BRIEF.md
# Master-Clock to Frame-Rate Ratio Detector

This block watches a master clock and a left/right frame clock and works out how many master clock cycles make up one audio frame. It measures each frame as the distance between consecutive rising edges of the frame clock. It then compares that length with the six supported oversampling ratios (128, 192, 256, 384, 512 and 768). A length matches a ratio when it lies within a fixed tolerance of that ratio, which by default is plus or minus 32 cycles.

A ratio is reported only after two consecutive frames agree on it. If no permitted ratio fits, the block raises an error and tells the downstream datapath to hold its last output sample. A chip uses one instance per converter direction. The `ALLOWED_MASK` parameter sets which ratios each instance accepts: all six for playback, and only 256 to 512 for capture. When the interface is clock master, the ratio is taken from a configuration input instead of being measured.

Top module: `ratio_detector`

## Requirements
- R1: The frame clock is brought into the master clock domain by two flops. The measured frame length is the number of master clock cycles between two consecutive rising edges of the frame clock.
- R2: A measured length matches candidate code i when the absolute difference from that ratio is at most TOL (default 32). The code-to-ratio mapping is 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768, and codes 6 and 7 are unused.
- R3: When a length matches two permitted candidates, the lower code is chosen. For example, 224 gives code 1 when code 1 is permitted.
- R4: A length that matches no permitted candidate is classified as a miss.
- R5: In slave mode the outputs change only when two consecutive measurements give the same classification. A single frame that deviates leaves the committed ratio unchanged.
- R6: A committed hit sets ratioValid=1 and ratioError=0. A committed miss sets ratioValid=0 and ratioError=1. In slave mode holdSample equals ratioError. The valid and error flags are never both high.
- R7: If 768+TOL+1 cycles pass without a rising edge, the block records a miss and restarts its count. The measurement that ends at the next rising edge is also a miss. A stopped frame clock therefore produces an error after two timeouts.
- R8: Bit i of `ALLOWED_MASK` permits code i. A committed valid code is always a permitted one.
- R9: When slaveMode=0, ratioCode equals cfgRatio. ratioValid is 1 exactly when cfgRatio is a permitted code, and ratioError and holdSample equal the inverse of that.
- R10: After reset, in slave mode, ratioValid, ratioError and holdSample are all 0 until the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameClk | input | 1 | Left/right frame clock, not yet synchronised |
| slaveMode | input | 1 | 1: measure the ratio; 0: use cfgRatio |
| cfgRatio | input | 3 | Ratio code used in master mode |
| ratioCode | output | 3 | Detected or configured ratio code |
| ratioValid | output | 1 | The ratio code is valid |
| ratioError | output | 1 | No permitted ratio matches |
| holdSample | output | 1 | Tells the datapath to hold its last sample |

## Verification
The hardest situations to reach from the ports are the ones the commit rule hides. These are a single deviating frame in the middle of a locked stream, jitter that alternates on both sides of a ratio, and a frame clock that stops long enough for exactly one or exactly two timeouts. Directed sequences build each of these frame by frame. They sample the outputs after one timeout and again after a second. Random bursts of constant frame lengths within ±40 of a random ratio then exercise both tolerance edges. Both a playback and a capture instance watch the same stimulus, which checks the mask and the overlap priority together.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W = 3;

  // Candidate oversampling ratios, ascending with the code
  function automatic int ratioOf(input int idx);
    case (idx)
      0: ratioOf = 128;
      1: ratioOf = 192;
      2: ratioOf = 256;
      3: ratioOf = 384;
      4: ratioOf = 512;
      default: ratioOf = 768;
    endcase
  endfunction

  // Measurement event from datapath to control
  typedef struct packed {
    logic              strobe;
    logic              hit;
    logic [CODE_W-1:0] code;
  } measEvt_t;
endpackage

// File: rtl/ratio_det_datapath.sv
module ratio_det_datapath
  import ratio_det_pkg::*;
#(
  parameter logic [NUM_RATIOS-1:0] ALLOWED_MASK = '1,
  parameter int TOL = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameClk,
  output measEvt_t evt
);
  localparam int SAT   = ratioOf(NUM_RATIOS-1) + TOL + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [2:0]       syncQ;
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic             stale;
  logic             hit;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], frameClk};
  end

  assign rise = syncQ[1] & ~syncQ[2];

  // Classifier: descending scan so the lowest matching code wins
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (ALLOWED_MASK[i]) begin
        if ((int'(cnt) - ratioOf(i) <= TOL) && (ratioOf(i) - int'(cnt) <= TOL)) begin
          hit  = 1'b1;
          code = CODE_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= CNT_W'(1);
      stale <= 1'b1;
      evt   <= '0;
    end else begin
      evt.strobe <= 1'b0;
      if (rise) begin
        evt   <= '{strobe: 1'b1, hit: hit & ~stale, code: code};
        cnt   <= CNT_W'(1);
        stale <= 1'b0;
      end else if (int'(cnt) == SAT) begin
        evt   <= '{strobe: 1'b1, hit: 1'b0, code: '0};
        cnt   <= CNT_W'(1);
        stale <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ratio_det_control.sv
module ratio_det_control
  import ratio_det_pkg::*;
#(
  parameter logic [NUM_RATIOS-1:0] ALLOWED_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  measEvt_t          evt,
  input  logic              slaveMode,
  input  logic [CODE_W-1:0] cfgRatio,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              ratioError,
  output logic              holdSample
);
  logic [7:0]        maskExt;
  logic              cfgOk;
  logic              havePrev;
  logic              prevHit;
  logic [CODE_W-1:0] prevCode;
  logic              lockValid;
  logic              lockErr;
  logic [CODE_W-1:0] lockCode;
  logic              agree;

  assign maskExt = 8'(ALLOWED_MASK);
  assign cfgOk   = maskExt[cfgRatio];
  assign agree   = havePrev && (prevHit == evt.hit) && (!evt.hit || prevCode == evt.code);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev  <= 1'b0;
      prevHit   <= 1'b0;
      prevCode  <= '0;
      lockValid <= 1'b0;
      lockErr   <= 1'b0;
      lockCode  <= '0;
    end else if (evt.strobe) begin
      havePrev <= 1'b1;
      prevHit  <= evt.hit;
      prevCode <= evt.code;
      if (agree) begin
        lockValid <= evt.hit;
        lockErr   <= ~evt.hit;
        if (evt.hit) lockCode <= evt.code;
      end
    end
  end

  always_comb begin
    if (slaveMode) begin
      ratioCode  = lockCode;
      ratioValid = lockValid;
      ratioError = lockErr;
    end else begin
      ratioCode  = cfgRatio;
      ratioValid = cfgOk;
      ratioError = ~cfgOk;
    end
    holdSample = ratioError;
  end
endmodule

// File: rtl/ratio_detector.sv
module ratio_detector
  import ratio_det_pkg::*;
#(
  parameter logic [NUM_RATIOS-1:0] ALLOWED_MASK = '1,
  parameter int TOL = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic       slaveMode,
  input  logic [2:0] cfgRatio,
  output logic [2:0] ratioCode,
  output logic       ratioValid,
  output logic       ratioError,
  output logic       holdSample
);
  measEvt_t evt;

  ratio_det_datapath #(.ALLOWED_MASK(ALLOWED_MASK), .TOL(TOL)) uDp (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .evt(evt)
  );

  ratio_det_control #(.ALLOWED_MASK(ALLOWED_MASK)) uCtl (
    .clk(clk), .rstN(rstN), .evt(evt), .slaveMode(slaveMode), .cfgRatio(cfgRatio),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .ratioError(ratioError),
    .holdSample(holdSample)
  );
endmodule

// File: rtl/ratio_det_chk.sv
module ratio_det_chk #(
  parameter logic [5:0] ALLOWED_MASK = '1
) (
  input logic       clk,
  input logic       rstN,
  input logic       slaveMode,
  input logic [2:0] cfgRatio,
  input logic [2:0] ratioCode,
  input logic       ratioValid,
  input logic       ratioError,
  input logic       holdSample,
  input logic       evtStrobe
);
  logic [7:0] maskExt;
  assign maskExt = 8'(ALLOWED_MASK);

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ratioValid && ratioError));

  // R6
  hold_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    ratioError |-> holdSample);

  // R8
  permitted_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |-> maskExt[ratioCode]);

  // R5
  no_event_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && $past(slaveMode) && !$past(evtStrobe)) |->
      ($stable(ratioCode) && $stable(ratioValid) && $stable(ratioError)));

  // R9
  master_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |-> (ratioCode == cfgRatio));
endmodule

bind ratio_detector ratio_det_chk #(.ALLOWED_MASK(ALLOWED_MASK)) uChk (
  .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .cfgRatio(cfgRatio),
  .ratioCode(ratioCode), .ratioValid(ratioValid), .ratioError(ratioError),
  .holdSample(holdSample), .evtStrobe(evt.strobe)
);

// File: tb/tb_ratio_detector.sv
module tb_ratio_detector;
  localparam logic [5:0] PLAY_MASK = 6'b111111;
  localparam logic [5:0] CAP_MASK  = 6'b011100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameClk = 1'b0;
  logic slaveMode = 1'b1;
  logic [2:0] cfgRatio = 3'd0;
  logic [2:0] codeP, codeC;
  logic validP, validC, errP, errC, holdP, holdC;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ratio_detector #(.ALLOWED_MASK(PLAY_MASK)) dut (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .slaveMode(slaveMode), .cfgRatio(cfgRatio),
    .ratioCode(codeP), .ratioValid(validP), .ratioError(errP), .holdSample(holdP)
  );

  ratio_detector #(.ALLOWED_MASK(CAP_MASK)) dutCap (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .slaveMode(slaveMode), .cfgRatio(cfgRatio),
    .ratioCode(codeC), .ratioValid(validC), .ratioError(errC), .holdSample(holdC)
  );

  function automatic int ratioVal(input int i);
    int tbl[6] = '{128, 192, 256, 384, 512, 768};
    return tbl[i];
  endfunction

  // Expected classification: returns code, or -1 for a miss
  function automatic int classify(input int len, input logic [5:0] mask);
    for (int i = 0; i < 6; i++) begin
      int d = len - ratioVal(i);
      if (mask[i] && d >= -32 && d <= 32) return i;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runFrames(input int len, input int n);
    for (int k = 0; k < n; k++) begin
      frameClk = 1'b1;
      waitCyc(len / 2);
      frameClk = 1'b0;
      waitCyc(len - len / 2);
    end
    waitCyc(6);
  endtask

  // Compare both instances against the expected classification
  task automatic expectBoth(input string req, input int len);
    int eP = classify(len, PLAY_MASK);
    int eC = classify(len, CAP_MASK);
    chk({req, " play valid"}, int'(validP), int'(eP >= 0));
    chk({req, " play error"}, int'(errP), int'(eP < 0));
    chk({req, " play hold"}, int'(holdP), int'(eP < 0));
    if (eP >= 0) chk({req, " play code"}, int'(codeP), eP);
    chk({req, " cap valid"}, int'(validC), int'(eC >= 0));
    chk({req, " cap error"}, int'(errC), int'(eC < 0));
    if (eC >= 0) chk({req, " cap code"}, int'(codeC), eC);
  endtask

  initial begin
    void'($urandom(32'd4242));
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(3);
    // R10 reset state
    chk("R10 valid", int'(validP), 0);
    chk("R10 error", int'(errP), 0);
    chk("R10 hold", int'(holdP), 0);

    // R1 R2 plain lock
    runFrames(256, 5);
    expectBoth("R1 R2 len256", 256);

    // R5 single deviating frame leaves lock untouched
    runFrames(384, 1);
    runFrames(256, 1);
    chk("R5 glitch code", int'(codeP), 2);
    chk("R5 glitch valid", int'(validP), 1);
    runFrames(256, 3);
    runFrames(384, 4);
    expectBoth("R5 switch 384", 384);

    // R2 jitter on both sides of 384
    for (int k = 0; k < 4; k++) begin
      runFrames(381, 1);
      runFrames(389, 1);
    end
    chk("R2 jitter code", int'(codeP), 3);
    chk("R2 jitter valid", int'(validP), 1);

    // R2 R4 R8 tolerance edges
    runFrames(736, 5);  expectBoth("R2 R8 len736", 736);
    runFrames(735, 5);  expectBoth("R4 len735", 735);
    runFrames(800, 5);  expectBoth("R2 len800", 800);
    // R3 overlap priority, and R8 mask on capture side
    runFrames(224, 5);  expectBoth("R3 len224", 224);
    chk("R3 play code 224", int'(codeP), 1);
    chk("R8 cap code 224", int'(codeC), 2);
    runFrames(160, 5);  expectBoth("R3 R8 len160", 160);

    // R7 stopped frame clock
    runFrames(512, 5);
    expectBoth("R7 prelock", 512);
    frameClk = 1'b0;
    waitCyc(700);
    chk("R7 one timeout valid", int'(validP), 1);
    chk("R7 one timeout code", int'(codeP), 4);
    waitCyc(800);
    chk("R7 two timeouts error", int'(errP), 1);
    chk("R7 two timeouts valid", int'(validP), 0);
    chk("R6 hold on stop", int'(holdP), 1);
    chk("R7 cap error", int'(errC), 1);
    // R6 recovery
    runFrames(256, 5);
    expectBoth("R6 recover", 256);

    // R9 master mode
    slaveMode = 1'b0;
    cfgRatio = 3'd3; waitCyc(2);
    chk("R9 code3", int'(codeP), 3);
    chk("R9 valid3", int'(validP), 1);
    chk("R9 cap valid3", int'(validC), 1);
    cfgRatio = 3'd0; waitCyc(2);
    chk("R9 cap valid0", int'(validC), 0);
    chk("R9 cap error0", int'(errC), 1);
    chk("R9 cap hold0", int'(holdC), 1);
    chk("R9 play valid0", int'(validP), 1);
    cfgRatio = 3'd7; waitCyc(2);
    chk("R9 code7", int'(codeP), 7);
    chk("R9 error7", int'(errP), 1);
    slaveMode = 1'b1;

    // Random bursts of constant frame length (R2 R3 R4 R8)
    for (int b = 0; b < 12; b++) begin
      int r = int'($urandom % 6);
      int off = int'($urandom % 81) - 40;
      int len = ratioVal(r) + off;
      runFrames(len, 5);
      expectBoth("R2 R4 random", len);
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule